// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles whether a conditional branch is taken, and where it goes, for a small 32-bit RISC pipeline with one delay slot. The issue stage gives it the current Z, C and N flags, a 5-bit condition code and the branch operands. Each cycle it returns a combinational taken decision, a branch target and the sequential address.

Two branch forms are handled. A relative branch adds a sign-extended 5-bit halfword offset to the address after the branch. An absolute jump takes a register value limited to a 24-bit, halfword-aligned address.

A taken branch does not redirect fetch at once. The target is latched and a pending flag rises, so the delay-slot instruction still runs. When the pipeline reports that this instruction has completed, the unit emits a one-cycle redirect pulse that carries the latched target.

Top module: `brc_unit`

## Requirements
- R1: The flags form a 3-bit index with Z in bit 0, C in bit 1 and N in bit 2. Condition bit 0 set makes the branch require Z=0. Condition bit 1 set makes it require Z=1.
- R2: Condition bit 4 selects the second flag: C when it is 0, N when it is 1. Condition bit 2 set requires the selected flag to be clear. Condition bit 3 set requires it to be set.
- R3: With condition bits 3..0 all zero the branch is always taken. Otherwise `br_taken` is 1 only when every enabled test passes.
- R4: When `br_absolute`=0, `br_target` = `cur_pc` + 2 + 2 × (sign-extended `rel_ofs`), modulo 2^32.
- R5: When `br_absolute`=1, `br_target` = `jump_reg` AND 0x00FFFFFE.
- R6: `next_pc` is always `cur_pc` + 2. A branch issued with a false condition leaves `slot_pending` low and produces no redirect.
- R7: A branch issued (`br_valid`=1) with a true condition while nothing is pending sets `slot_pending` after the clock edge and latches its target into `redirect_pc`.
- R8: While `slot_pending` is 1, a cycle with `slot_done`=1 clears `slot_pending` and drives `redirect` high for exactly the following cycle. `redirect_pc` still holds the latched target. `slot_done` has no effect while nothing is pending.
- R9: While `slot_pending` is 1, a newly issued branch is ignored: `redirect_pc` and `slot_pending` are unchanged.
- R10: During and right after reset, `slot_pending` and `redirect` are 0 and `redirect_pc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch is issued this cycle |
| br_absolute | input | 1 | 1: absolute register jump, 0: relative branch |
| cond_code | input | 5 | Condition code |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| rel_ofs | input | 5 | Signed halfword offset for relative branches |
| jump_reg | input | 32 | Register value for absolute jumps |
| cur_pc | input | 32 | Address of the branch instruction |
| slot_done | input | 1 | The delay-slot instruction completes this cycle |
| br_taken | output | 1 | Condition result for the current inputs |
| br_target | output | 32 | Target computed from the current inputs |
| next_pc | output | 32 | Sequential address, cur_pc + 2 |
| slot_pending | output | 1 | A taken branch is waiting for its delay slot |
| redirect | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | Latched target of the pending or redirecting branch |

## Verification
The bench drives all 32 condition codes against all eight flag combinations. This exposes a swapped flag index, an inverted Z test or a bit-4 select that picks the wrong flag, each of which would take branches that should fall through. The extreme offsets −16 and +15 and an all-ones jump register catch a missing sign extension, a missing doubling or a lost alignment mask, which would send fetch to a wrong address. The pending sequence stresses a second branch issued inside the delay slot and a stray `slot_done` with nothing pending. It also checks the cycle in which the pulse appears: a design that overwrote the target, redirected early or held the pulse for two cycles would show a mismatch there.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned FLAG_IDX_W = 3;
  localparam int unsigned IDX_Z = 0;
  localparam int unsigned IDX_C = 1;
  localparam int unsigned IDX_N = 2;

  localparam int unsigned CC_ZCLR = 0;
  localparam int unsigned CC_ZSET = 1;
  localparam int unsigned CC_FCLR = 2;
  localparam int unsigned CC_FSET = 3;
  localparam int unsigned CC_SELN = 4;

  typedef logic [FLAG_IDX_W-1:0] flag_idx_t;

  function automatic flag_idx_t pack_flags(input logic z, input logic c, input logic n);
    flag_idx_t f;
    f        = '0;
    f[IDX_Z] = z;
    f[IDX_C] = c;
    f[IDX_N] = n;
    return f;
  endfunction
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
#(
  parameter int unsigned COND_W = 5
) (
  input  logic [COND_W-1:0] cond_code,
  input  flag_idx_t         flags,
  output logic              cond_ok
);
  logic sel_flag;
  logic fail_zclr, fail_zset, fail_fclr, fail_fset;

  always_comb begin
    sel_flag  = cond_code[CC_SELN] ? flags[IDX_N] : flags[IDX_C];
    fail_zclr = cond_code[CC_ZCLR] &  flags[IDX_Z];
    fail_zset = cond_code[CC_ZSET] & ~flags[IDX_Z];
    fail_fclr = cond_code[CC_FCLR] &  sel_flag;
    fail_fset = cond_code[CC_FSET] & ~sel_flag;
    cond_ok   = ~(fail_zclr | fail_zset | fail_fclr | fail_fset);
  end
endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 5,
  parameter int unsigned JMP_W  = 24
) (
  input  logic              use_abs,
  input  logic [OFS_W-1:0]  rel_ofs,
  input  logic [ADDR_W-1:0] jump_reg,
  input  logic [ADDR_W-1:0] cur_pc,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] target
);
  localparam int unsigned EXT_W = ADDR_W - OFS_W;
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ABS_MASK =
    {{(ADDR_W-JMP_W){1'b0}}, {(JMP_W-1){1'b1}}, 1'b0};

  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] rel_tgt;
  logic [ADDR_W-1:0] abs_tgt;

  always_comb begin
    seq_pc  = cur_pc + INSN_BYTES;
    ofs_ext = {{EXT_W{rel_ofs[OFS_W-1]}}, rel_ofs};
    rel_tgt = seq_pc + {ofs_ext[ADDR_W-2:0], 1'b0};
    abs_tgt = jump_reg & ABS_MASK;
    target  = use_abs ? abs_tgt : rel_tgt;
  end
endmodule

// File: rtl/brc_redirect_ctl.sv
module brc_redirect_ctl #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  input  logic              slot_done,
  output logic              pending,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_pc
);
  logic              pend_q, pend_d;
  logic              redir_q, redir_d;
  logic [ADDR_W-1:0] tgt_q;
  logic              tgt_en;

  always_comb begin
    pend_d  = pend_q;
    redir_d = 1'b0;
    tgt_en  = 1'b0;
    if (pend_q) begin
      if (slot_done) begin
        pend_d  = 1'b0;
        redir_d = 1'b1;
      end
    end else if (issue && taken) begin
      pend_d = 1'b1;
      tgt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      redir_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      redir_q <= redir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= target;
  end

  assign pending     = pend_q;
  assign redirect    = redir_q;
  assign redirect_pc = tgt_q;

  // R8
  redirect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  // R8
  redirect_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && slot_done) |=> (redirect && !pending));

  // R9
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !slot_done) |=> (pending && $stable(redirect_pc)));

  // R7
  pending_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && issue && taken) |=> (pending && redirect_pc == $past(target)));
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 5,
  parameter int unsigned COND_W = 5,
  parameter int unsigned JMP_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic              br_absolute,
  input  logic [COND_W-1:0] cond_code,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_n,
  input  logic [OFS_W-1:0]  rel_ofs,
  input  logic [ADDR_W-1:0] jump_reg,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              slot_done,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] next_pc,
  output logic              slot_pending,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_pc
);
  flag_idx_t flags;
  assign flags = pack_flags(flag_z, flag_c, flag_n);

  brc_cond_eval #(.COND_W(COND_W)) u_cond (
    .cond_code (cond_code),
    .flags     (flags),
    .cond_ok   (br_taken)
  );

  brc_target_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .JMP_W(JMP_W)) u_tgt (
    .use_abs  (br_absolute),
    .rel_ofs  (rel_ofs),
    .jump_reg (jump_reg),
    .cur_pc   (cur_pc),
    .seq_pc   (next_pc),
    .target   (br_target)
  );

  brc_redirect_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (br_valid),
    .taken       (br_taken),
    .target      (br_target),
    .slot_done   (slot_done),
    .pending     (slot_pending),
    .redirect    (redirect),
    .redirect_pc (redirect_pc)
  );

  // R3
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code[3:0] == 4'b0000) |-> br_taken);

  // R5
  abs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_absolute |-> (br_target[0] == 1'b0 && br_target[ADDR_W-1:JMP_W] == '0));

  // R1
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code[0] && flag_z) |-> !br_taken);

  // R6
  not_taken_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_pending && br_valid && !br_taken) |=> !slot_pending);
endmodule

// File: tb/brc_unit_bench.sv
module brc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_valid, br_absolute, flag_z, flag_c, flag_n, slot_done;
  logic [4:0]  cond_code, rel_ofs;
  logic [31:0] jump_reg, cur_pc;
  logic        br_taken, slot_pending, redirect;
  logic [31:0] br_target, next_pc, redirect_pc;

  int total = 0;
  int bad   = 0;
  bit over  = 0;

  bit          m_pend;
  bit          m_redir;
  logic [31:0] m_tgt;

  always #5 clk = ~clk;

  brc_unit u_brc_unit (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_absolute(br_absolute),
    .cond_code(cond_code), .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n),
    .rel_ofs(rel_ofs), .jump_reg(jump_reg), .cur_pc(cur_pc), .slot_done(slot_done),
    .br_taken(br_taken), .br_target(br_target), .next_pc(next_pc),
    .slot_pending(slot_pending), .redirect(redirect), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_taken(input logic [4:0] cc, input bit z, input bit c, input bit n);
    bit second;
    bit ok;
    ok = 1;
    if (cc[4]) second = n; else second = c;
    if (cc[0] && z)       ok = 0;
    if (cc[1] && !z)      ok = 0;
    if (cc[2] && second)  ok = 0;
    if (cc[3] && !second) ok = 0;
    return ok;
  endfunction

  function automatic logic [31:0] ref_target(input bit absj, input logic [4:0] ofs,
                                             input logic [31:0] jr, input logic [31:0] pc);
    int off;
    if (absj) return jr & 32'h00FF_FFFE;
    off = (ofs > 15) ? int'(ofs) - 32 : int'(ofs);
    return pc + 32'd2 + 32'(2 * off);
  endfunction

  // drive one cycle, starting just after a rising edge
  task automatic step(input string req, input bit v, input bit absj, input logic [4:0] cc,
                      input bit z, input bit c, input bit n, input logic [4:0] ofs,
                      input logic [31:0] jr, input logic [31:0] pc, input bit sd);
    bit          e_ok;
    logic [31:0] e_tgt;
    br_valid = v; br_absolute = absj; cond_code = cc; flag_z = z; flag_c = c; flag_n = n;
    rel_ofs = ofs; jump_reg = jr; cur_pc = pc; slot_done = sd;
    #2;
    e_ok  = ref_taken(cc, z, c, n);
    e_tgt = ref_target(absj, ofs, jr, pc);
    chk(req, "br_taken", 32'(br_taken), 32'(e_ok));
    chk(req, "br_target", br_target, e_tgt);
    chk("R6", "next_pc", next_pc, pc + 32'd2);
    m_redir = 0;
    if (m_pend) begin
      if (sd) begin m_pend = 0; m_redir = 1; end
    end else if (v && e_ok) begin
      m_pend = 1; m_tgt = e_tgt;
    end
    @(posedge clk); #1;
    chk("R7_R8_R9", "slot_pending", 32'(slot_pending), 32'(m_pend));
    chk("R8", "redirect", 32'(redirect), 32'(m_redir));
    chk("R7_R9", "redirect_pc", redirect_pc, m_tgt);
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; br_valid = 0; br_absolute = 0; cond_code = 0; flag_z = 0; flag_c = 0;
    flag_n = 0; rel_ofs = 0; jump_reg = 0; cur_pc = 0; slot_done = 0;
    m_pend = 0; m_redir = 0; m_tgt = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10 during reset
    chk("R10", "slot_pending", 32'(slot_pending), 0);
    chk("R10", "redirect", 32'(redirect), 0);
    chk("R10", "redirect_pc", redirect_pc, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R10", "slot_pending", 32'(slot_pending), 0);
    chk("R10", "redirect_pc", redirect_pc, 0);

    // R1 R2 R3: every condition code against every flag combination
    for (int cc = 0; cc < 32; cc++) begin
      for (int f = 0; f < 8; f++) begin
        step((cc[3:0] == 0) ? "R3" : "R1_R2", 0, 0, 5'(cc), f[0], f[1], f[2],
             5'(cc), 32'h0000_1000 + 32'(cc * 64), 32'h0000_4000 + 32'(f * 16), 0);
      end
    end

    // R4: extreme and zero offsets, wrap near the top of the space
    step("R4", 0, 0, 5'd0, 0, 0, 0, 5'b10000, 0, 32'h0000_0100, 0);
    step("R4", 0, 0, 5'd0, 0, 0, 0, 5'b01111, 0, 32'h0000_0100, 0);
    step("R4", 0, 0, 5'd0, 0, 0, 0, 5'b00000, 0, 32'hFFFF_FFFE, 0);
    step("R4", 0, 0, 5'd0, 0, 0, 0, 5'b11111, 0, 32'h0000_0000, 0);
    // R5: masking and alignment
    step("R5", 0, 1, 5'd0, 0, 0, 0, 5'd3, 32'hFFFF_FFFF, 32'h10, 0);
    step("R5", 0, 1, 5'd0, 0, 0, 0, 5'd3, 32'h0012_3457, 32'h10, 0);

    // R6: issued branch with false condition (Z required clear, Z=1)
    step("R6", 1, 0, 5'b00001, 1, 0, 0, 5'd4, 0, 32'h200, 0);
    // R8: slot_done with nothing pending has no effect
    step("R8", 0, 0, 5'd0, 0, 0, 0, 5'd0, 0, 32'h202, 1);

    // R7: taken relative branch, then delay slot held for two cycles
    step("R7", 1, 0, 5'b01000, 0, 1, 0, 5'b11110, 0, 32'h300, 0);
    step("R7", 0, 0, 5'd0, 0, 0, 0, 5'd0, 0, 32'h302, 0);
    // R9: second branch while pending is ignored
    step("R9", 1, 1, 5'd0, 0, 0, 0, 5'd0, 32'h00AB_CDE0, 32'h302, 0);
    // R8: slot completes, pulse follows, then drops
    step("R8", 0, 0, 5'd0, 0, 0, 0, 5'd0, 0, 32'h304, 1);
    step("R8", 0, 0, 5'd0, 0, 0, 0, 5'd0, 0, 32'h306, 0);

    // R7 R8: absolute jump taken in the same cycle as a stray slot_done, N-selected test
    step("R7", 1, 1, 5'b11000, 0, 0, 1, 5'd0, 32'hFF55_AA33, 32'h400, 1);
    step("R8", 0, 0, 5'd0, 0, 0, 0, 5'd0, 0, 32'h402, 1);
    step("R8", 0, 0, 5'd0, 0, 0, 0, 5'd0, 0, 32'h404, 0);

    // back-to-back: new branch right after the pulse
    step("R7", 1, 0, 5'd0, 0, 0, 0, 5'd7, 0, 32'h500, 0);
    step("R8", 0, 0, 5'd0, 0, 0, 0, 5'd0, 0, 32'h502, 1);
    step("R8", 0, 0, 5'd0, 0, 0, 0, 5'd0, 0, 32'h504, 0);

    finish_run();
  end
endmodule